// File: doc/BRIEF.md
# Pre-fetch Resampling Comparator Unit

This block is the decision core of a particle-filter resampling engine. It reads cumulative particle weights ahead of need into a short queue of up to `D` entries and tests every queued weight against the current ordered random value at once. The lowest queue slot whose weight is at least the random value picks the particle that is replicated. When no slot qualifies, the whole queue is dropped and reading carries on. Reading ahead during the cycles that accept a random value cuts down the cycles in which no particle is produced.

A run begins with a one-cycle `start` pulse. The unit then reads the weight memory at addresses 0 upward, one per cycle, and takes ordered random values through a valid/ready handshake. It emits one particle index per accepted random value. After `M` indices it raises `done`, and `lat_cycles` holds the number of cycles in which the queue was dropped without an index being produced.

Top module: `prefetch_resampler`

## Requirements
- R1: After reset and after a `start` pulse, `idx_valid`, `done`, `rnd_ready` and `wt_rd_en` are 0 and `lat_cycles` is 0.
- R2: While a run is active, a weight read is issued whenever the queue, counting a read still in flight, would hold fewer than `D` entries after the current cycle. Reads use addresses 0, 1, 2 … in order, never go past `M-1`, and return data one cycle later.
- R3: A slot is a hit when `rnd_data <= weight`, compared unsigned. The lowest hit slot `j` selects particle `k+j`, where `k` is the particle index of the queue head.
- R4: A hit in slot 0 removes no queue entry and emits the head particle index.
- R5: A hit in slot `j > 0` drops entries 0 to `j-1`, so entry `j` becomes the head.
- R6: When the queue is not empty and every entry is below a valid random value, with weights still to come, the whole queue is dropped and no index is emitted. The random value is not consumed, and `lat_cycles` increases by 1.
- R7: `rnd_ready` is high only in a cycle that decides an index. That index appears on `idx_data` with `idx_valid` one cycle later.
- R8: Once all `M` weights have arrived and no queued entry is a hit, each valid random value is consumed and emits index `M-1`.
- R9: After exactly `M` indices, `done` pulses for one cycle together with the last `idx_valid`. Reads and handshakes then stop until the next `start`.
- R10: While `rnd_valid` is low, no random value is consumed and no index is emitted, but the queue keeps filling until it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a resampling run |
| wt_rd_en | output | 1 | Weight memory read enable |
| wt_rd_addr | output | $clog2(M) | Weight memory read address |
| wt_rd_data | input | WW | Cumulative weight, valid one cycle after the read |
| rnd_valid | input | 1 | Ordered random value available |
| rnd_data | input | WW | Ordered random value, on the weight scale |
| rnd_ready | output | 1 | Random value consumed this cycle |
| idx_valid | output | 1 | Resampled particle index valid |
| idx_data | output | $clog2(M) | Resampled particle index |
| done | output | 1 | Run complete pulse |
| lat_cycles | output | $clog2(M)+1 | Count of queue-drop cycles in the run |

## Verification
The hardest situation to reach from the ports is a hit deep in a full queue, where several entries are dropped in one cycle. The stimulus builds it with runs of zero-weight particles, so that equal cumulative values sit in a row, and with gaps in `rnd_valid` that let the queue fill before a random value is presented. Exhaustion with rounding is reached by random values that run past the total weight. Equality ties are reached by random values exactly equal to a repeated cumulative weight.

// File: rtl/prefetch_resampler.sv
module prefetch_resampler #(
  parameter int D  = 5,
  parameter int M  = 16,
  parameter int WW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   wt_rd_en,
  output logic [$clog2(M)-1:0]   wt_rd_addr,
  input  logic [WW-1:0]          wt_rd_data,
  input  logic                   rnd_valid,
  input  logic [WW-1:0]          rnd_data,
  output logic                   rnd_ready,
  output logic                   idx_valid,
  output logic [$clog2(M)-1:0]   idx_data,
  output logic                   done,
  output logic [$clog2(M):0]     lat_cycles
);
  localparam int IW = $clog2(M);
  localparam int FW = $clog2(D + 1);
  localparam int JW = (D > 1) ? $clog2(D) : 1;

  logic [WW-1:0] q [D];
  logic [WW-1:0] qn [D];
  logic [FW-1:0] fill, sh, keep, fill_n;
  logic [IW:0]   head, rd_addr, cnt;
  logic          running, rd_pend;
  logic [D-1:0]  hit;
  logic [JW-1:0] j;
  logic          any_hit, exhausted, take, flush, last;
  logic [IW-1:0] out_idx;

  always_comb begin
    for (int i = 0; i < D; i++) hit[i] = (FW'(i) < fill) && (rnd_data <= q[i]);
    j = '0;
    for (int i = D - 1; i >= 0; i--) if (hit[i]) j = JW'(i);
  end

  assign any_hit   = |hit;
  assign exhausted = (rd_addr == (IW+1)'(M)) && !rd_pend;
  assign take      = running && rnd_valid && (any_hit || exhausted);
  assign flush     = running && rnd_valid && !any_hit && !exhausted && (fill != '0);
  assign last      = take && (cnt == (IW+1)'(M - 1));
  assign sh        = any_hit ? FW'(j) : ((take || flush) ? fill : '0);
  assign keep      = fill - sh;
  assign fill_n    = keep + FW'(rd_pend);
  assign out_idx   = any_hit ? IW'(head + (IW+1)'(j)) : IW'(M - 1);

  always_comb begin
    for (int i = 0; i < D; i++) begin
      qn[i] = '0;
      if (i + int'(sh) < D) qn[i] = q[i + int'(sh)];
    end
    if (rd_pend && (int'(keep) < D)) qn[keep] = wt_rd_data;
  end

  assign wt_rd_en   = running && !last && (rd_addr < (IW+1)'(M)) && (int'(fill_n) < D);
  assign wt_rd_addr = rd_addr[IW-1:0];
  assign rnd_ready  = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) q[i] <= '0;
      fill <= '0; head <= '0; rd_addr <= '0; cnt <= '0;
      running <= 1'b0; rd_pend <= 1'b0;
      idx_valid <= 1'b0; idx_data <= '0; done <= 1'b0; lat_cycles <= '0;
    end else if (start) begin
      fill <= '0; head <= '0; rd_addr <= '0; cnt <= '0;
      running <= 1'b1; rd_pend <= 1'b0;
      idx_valid <= 1'b0; idx_data <= '0; done <= 1'b0; lat_cycles <= '0;
    end else begin
      for (int i = 0; i < D; i++) q[i] <= qn[i];
      fill       <= fill_n;
      head       <= head + (IW+1)'(sh);
      rd_pend    <= wt_rd_en;
      rd_addr    <= rd_addr + (IW+1)'(wt_rd_en);
      cnt        <= cnt + (IW+1)'(take);
      running    <= running && !last;
      idx_valid  <= take;
      idx_data   <= take ? out_idx : idx_data;
      done       <= last;
      lat_cycles <= lat_cycles + (IW+1)'(flush);
    end
  end

  logic [IW-1:0] prev_idx;
  logic          seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_idx <= '0; seen <= 1'b0;
    end else if (start) begin
      seen <= 1'b0;
    end else if (idx_valid) begin
      prev_idx <= idx_data; seen <= 1'b1;
    end
  end

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill) + int'(rd_pend)) <= D);
  // R7
  idx_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> $past(rnd_valid && rnd_ready));
  // R7
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_ready |-> rnd_valid);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_with_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idx_valid);
  // R3
  idx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && seen) |-> (idx_data >= prev_idx));
endmodule

// File: tb/prefetch_resampler_test.sv
module prefetch_resampler_test;
  localparam int D = 5, M = 16, WW = 16, IW = $clog2(M);

  logic clk = 0, rst_n = 0, start = 0;
  logic wt_rd_en, rnd_valid = 0, rnd_ready, idx_valid, done;
  logic [IW-1:0] wt_rd_addr, idx_data;
  logic [WW-1:0] wt_rd_data = '0, rnd_data = '0;
  logic [IW:0] lat_cycles;

  always #10 clk = ~clk;

  prefetch_resampler #(.D(D), .M(M), .WW(WW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .wt_rd_en(wt_rd_en), .wt_rd_addr(wt_rd_addr), .wt_rd_data(wt_rd_data),
    .rnd_valid(rnd_valid), .rnd_data(rnd_data), .rnd_ready(rnd_ready),
    .idx_valid(idx_valid), .idx_data(idx_data), .done(done), .lat_cycles(lat_cycles));

  logic [WW-1:0] mem [M];
  int rq [M];
  always @(posedge clk) if (wt_rd_en) wt_rd_data <= mem[wt_rd_addr];

  int checks = 0, failures = 0;
  int mq[$];
  int got[$];
  int mk, maddr, pend_addr, mcnt, mlat, ptr, cyc;
  bit mpend, mrun, midx_v, mdone;
  int midx;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit st, bit gap);
    int j, sh;
    bit take, flush, exh, last, en;
    chk(idx_valid == midx_v, "R7 idx_valid", idx_valid, midx_v);
    if (midx_v) chk(idx_data == midx, "R3 idx_data", idx_data, midx);
    chk(done == mdone, "R9 done", done, mdone);
    chk(lat_cycles == mlat, "R6 lat_cycles", lat_cycles, mlat);
    if (idx_valid) got.push_back(idx_data);
    start = st;
    rnd_valid = !st && mrun && ptr < M && !(gap && (cyc % 3 != 0));
    rnd_data = (ptr < M) ? WW'(rq[ptr]) : '0;
    cyc++;
    #1;
    j = -1;
    for (int i = 0; i < mq.size(); i++) if (j < 0 && rq[ptr < M ? ptr : 0] <= mq[i]) j = i;
    exh = (maddr == M) && !mpend;
    take = mrun && rnd_valid && (j >= 0 || exh);
    flush = mrun && rnd_valid && j < 0 && !exh && mq.size() > 0;
    last = take && mcnt == M - 1;
    chk(rnd_ready == take, "R7 rnd_ready", rnd_ready, take);
    midx = (j >= 0) ? mk + j : M - 1;
    sh = (j >= 0) ? j : ((take || flush) ? mq.size() : 0);
    for (int i = 0; i < sh; i++) void'(mq.pop_front());
    mk += sh;
    if (mpend) mq.push_back(int'(mem[pend_addr]));
    en = mrun && !last && maddr < M && mq.size() < D;
    chk(wt_rd_en == en, "R2 wt_rd_en", wt_rd_en, en);
    if (en) chk(wt_rd_addr == IW'(maddr), "R2 wt_rd_addr", wt_rd_addr, maddr);
    if (st) begin
      mq.delete(); mk = 0; maddr = 0; mpend = 0; mcnt = 0; mlat = 0;
      mrun = 1; midx_v = 0; mdone = 0; ptr = 0; got.delete();
    end else begin
      midx_v = take; mdone = last; mlat += flush; mcnt += take;
      mrun = mrun && !last; mpend = en; pend_addr = maddr; maddr += en;
      if (take) ptr++;
    end
  endtask

  task automatic run_case(bit gap);
    int n = 0;
    @(negedge clk); step(1, gap);
    while (!mdone && n < 400) begin @(negedge clk); step(0, gap); n++; end
    @(negedge clk); step(0, gap);
    chk(n < 400, "R9 watchdog", n, 400);
    chk(got.size() == M, "R9 index count", got.size(), M);
  endtask

  initial begin
    int acc, s, c15;
    repeat (3) @(negedge clk);
    rst_n = 1;
    mq.delete(); mrun = 0; midx_v = 0; mdone = 0; mlat = 0; mpend = 0; ptr = M; cyc = 0;
    @(negedge clk); #1;
    chk(idx_valid == 0, "R1 idx_valid", idx_valid, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(rnd_ready == 0, "R1 rnd_ready", rnd_ready, 0);
    chk(wt_rd_en == 0, "R1 wt_rd_en", wt_rd_en, 0);
    chk(lat_cycles == 0, "R1 lat_cycles", lat_cycles, 0);

    // R4 uniform weights, one sample per stratum
    for (int i = 0; i < M; i++) begin mem[i] = WW'((i + 1) * 64); rq[i] = i * 64 + 32; end
    run_case(0);
    for (int i = 0; i < M && i < got.size(); i++) chk(got[i] == i, "R4 uniform index", got[i], i);
    chk(lat_cycles == 0, "R6 no drop cycles", lat_cycles, 0);

    // R6 all weight on the last particle
    for (int i = 0; i < M; i++) begin mem[i] = (i == M - 1) ? 16'd1000 : 16'd0; rq[i] = 10 * (i + 1); end
    run_case(0);
    for (int i = 0; i < got.size(); i++) chk(got[i] == M - 1, "R6 heavy tail index", got[i], M - 1);
    chk(lat_cycles >= 1, "R6 drop counted", lat_cycles, 1);

    // R5 zero-weight run then deep hit, queue filled during gaps
    for (int i = 0; i < M; i++) begin mem[i] = (i < 4) ? 16'd5 : WW'(25 + (i - 4) * 20); rq[i] = 10 + i * 15; end
    run_case(1);
    chk(got.size() > 0 && got[0] == 4, "R5 deep hit index", got.size() > 0 ? got[0] : -1, 4);

    // R3 equality tie resolves to lowest slot
    for (int i = 0; i < M; i++) begin mem[i] = (i < 3) ? 16'd50 : WW'(50 * (i - 1)); rq[i] = 50 * (i + 1); end
    run_case(1);
    chk(got.size() > 0 && got[0] == 0, "R3 tie lowest slot", got.size() > 0 ? got[0] : -1, 0);

    // R8 random values beyond the total weight
    for (int i = 0; i < M; i++) begin mem[i] = WW'((i + 1) * 10); rq[i] = i * 12 + 5; end
    run_case(0);
    c15 = 0;
    for (int i = 0; i < got.size(); i++) if (got[i] == M - 1) c15++;
    chk(c15 == 3, "R8 exhausted emits last index", c15, 3);

    // R10 irregular weights with gaps on the random stream
    acc = 0; s = 37;
    for (int i = 0; i < M; i++) begin
      s = (s * 73 + 19) % 251; acc += (s % 40); mem[i] = WW'(acc);
    end
    for (int i = 0; i < M; i++) rq[i] = (acc * (2 * i + 1)) / (2 * M) + ((i * 7) % 5);
    run_case(1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule